// File: doc/BRIEF.md
# ULPI Three-Pin Serial Mode Controller

This block is the digital control logic on the transceiver side of a ULPI link. It decodes register writes from the link over the 8-bit data bus, using the DIR/NXT/STP handshake, into two small registers. The first is an interface control register, which holds a serial-mode enable bit and a clock-keep bit. The second is an interrupt enable mask.

When the link sets the serial-mode enable bit, the bus stops carrying ULPI commands and switches to a three-pin full-speed/low-speed serial interface. Lane 0 is a transmit enable driven by the link. Lanes 1 and 2 carry differential data and single-ended zero. Their direction follows lane 0: they go toward the USB lines while transmit enable is high and report the received line state while it is low. Lane 3 is a level interrupt output. The lanes above 3 are quiet.

The link leaves serial mode by asserting STP. This clears the enable bit and returns the bus to normal ULPI direction control. While serial mode is active, the clock output keeps running only if the clock-keep bit is set.

Top module: `ulpi_serial3_ctrl`

## Requirements
- R1: After reset, `ulpi_dir`, `ulpi_nxt`, `ulpi_data_oe` and `usb_tx_en` are all 0, and `clkout_en` is 1.
- R2: Outside serial mode, a bus byte whose bits [7:6] are 2'b10 is a register write command, with the register address in bits [5:0]. `ulpi_nxt` is high during exactly the next cycle. The byte present in that cycle is taken as the write data. The register is updated at the first later clock edge on which `ulpi_stp` is high.
- R3: If `ulpi_stp` is high in the cycle where `ulpi_nxt` is high, the write is dropped. A write to any address other than 0x07 (interface control) or 0x0E (interrupt enable) changes nothing.
- R4: Writing 0x07 with bit 0 set enters serial mode. `ulpi_dir` goes high and lane 3 is driven. Lanes 7..4 have output enable 0 and output value 0.
- R5: In serial mode with lane 0 high, `usb_tx_en` is 1, `usb_tx_dat` follows lane 1 and `usb_tx_se0` follows lane 2. Lanes 1 and 2 are not driven, and their output value is 0.
- R6: In serial mode with lane 0 low, lanes 1 and 2 are driven with `line_dp_rx` and `line_se0_rx`, each delayed by two clock edges. `usb_tx_en`, `usb_tx_dat` and `usb_tx_se0` are all 0.
- R7: In serial mode, lane 3 is the OR over i of `irq_src[i]` AND mask bit i. The sources are bit 0 VBUS valid, bit 1 session valid, bit 2 session end and bit 3 ID change. The mask is bits [3:0] of register 0x0E and resets to 0.
- R8: `ulpi_stp` high in serial mode clears the enable bit at that edge. After it, `ulpi_dir` is 0, all lanes are undriven, and register writes work again.
- R9: `clkout_en` is 0 in serial mode unless bit 1 of register 0x07 is set. Outside serial mode it is 1.
- R10: In serial mode, bus bytes are not decoded as commands, so `ulpi_nxt` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ulpi_data_in | input | 8 | Data bus value as seen from the pins |
| ulpi_data_out | output | 8 | Value the block places on each lane |
| ulpi_data_oe | output | 8 | Per-lane output enable |
| ulpi_dir | output | 1 | Bus direction, high while serial mode is active |
| ulpi_nxt | output | 1 | Command accept strobe |
| ulpi_stp | input | 1 | Stop from the link |
| line_dp_rx | input | 1 | Received differential data from the line receiver |
| line_se0_rx | input | 1 | Received single-ended zero from the line receiver |
| usb_tx_en | output | 1 | Transmit enable toward the line drivers |
| usb_tx_dat | output | 1 | Differential transmit data |
| usb_tx_se0 | output | 1 | Single-ended zero transmit request |
| irq_src | input | 4 | Interrupt source levels |
| clkout_en | output | 1 | Enable for the clock output gate |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, four interrupt sources, a two-stage synchroniser and the register addresses 0x07 and 0x0E. With these values, the two-edge receive delay can be checked cycle by cycle. The four upper lanes that must stay quiet can be checked, and the mask value 0x05 separates masked sources from unmasked ones. Because the address width is six bits, the bench can also aim a write at an unused address and aim aborted writes at the control register itself.

// File: rtl/u3s_pkg.sv
package u3s_pkg;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_NXT   = 2'd1,
    WR_WAIT  = 2'd2
  } wr_state_t;

  // bit positions inside the interface control register
  localparam int unsigned CTL_SER_BIT  = 0;
  localparam int unsigned CTL_KEEP_BIT = 1;

  // lane roles while serial mode is active
  localparam int unsigned LANE_TXEN = 0;
  localparam int unsigned LANE_DAT  = 1;
  localparam int unsigned LANE_SE0  = 2;
  localparam int unsigned LANE_IRQ  = 3;

  function automatic logic is_reg_write(input logic [7:0] b);
    return (b[7:6] == 2'b10);
  endfunction

  function automatic logic irq_any(input logic [15:0] src, input logic [15:0] mask);
    return |(src & mask);
  endfunction

  function automatic logic clk_running(input logic active, input logic keep);
    return (!active) || keep;
  endfunction

endpackage

// File: rtl/u3s_regwr.sv
module u3s_regwr
  import u3s_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              stp,
  output logic              nxt,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data
);

  wr_state_t         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic              cmd_seen;

  assign cmd_seen = is_reg_write(8'(bus_in)) && !stp && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (hold) begin
      state_q <= WR_IDLE;
    end else begin
      case (state_q)
        WR_IDLE: begin
          if (cmd_seen) begin
            state_q <= WR_NXT;
            addr_q  <= bus_in[ADDR_W-1:0];
          end
        end
        WR_NXT: begin
          if (stp) begin
            state_q <= WR_IDLE;
          end else begin
            data_q  <= bus_in;
            state_q <= WR_WAIT;
          end
        end
        WR_WAIT: begin
          if (stp) state_q <= WR_IDLE;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  assign nxt       = (state_q == WR_NXT);
  assign wr_commit = (state_q == WR_WAIT) && stp && !hold;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;

  // R2: accept strobe one cycle after a command byte
  p_nxt_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WR_IDLE && cmd_seen) |=> nxt);

  // R2: the strobe lasts a single cycle
  p_nxt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nxt |=> !nxt);

  // R3: stop during the strobe drops the write
  p_abort_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt && stp) |=> !wr_commit);

endmodule

// File: rtl/u3s_ctrlregs.sv
module u3s_ctrlregs
  import u3s_pkg::*;
#(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned N_IRQ    = 4,
  parameter logic [ADDR_W-1:0] IFC_ADDR = 6'h07,
  parameter logic [ADDR_W-1:0] IEN_ADDR = 6'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              exit_evt,
  output logic              ser_en,
  output logic              clk_keep,
  output logic [N_IRQ-1:0]  irq_mask
);

  logic hit_ifc, hit_ien;

  assign hit_ifc = wr_commit && (wr_addr == IFC_ADDR);
  assign hit_ien = wr_commit && (wr_addr == IEN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_en   <= 1'b0;
      clk_keep <= 1'b0;
    end else if (hit_ifc) begin
      ser_en   <= wr_data[CTL_SER_BIT];
      clk_keep <= wr_data[CTL_KEEP_BIT];
    end else if (exit_evt) begin
      ser_en   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_mask <= '0;
    else if (hit_ien) irq_mask <= wr_data[N_IRQ-1:0];
  end

  // R8: stop in serial mode always clears the enable
  p_exit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !ser_en);

  // R3: writes elsewhere leave the control register alone
  p_other_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ifc && !exit_evt) |=> $stable(ser_en) && $stable(clk_keep));

endmodule

// File: rtl/u3s_sync.sv
module u3s_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/u3s_busmux.sv
module u3s_busmux
  import u3s_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_active,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             dp_sync,
  input  logic             se0_sync,
  input  logic             irq_level,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe,
  output logic             utx_en,
  output logic             utx_dat,
  output logic             utx_se0
);

  logic tx_mode, rx_mode;

  assign tx_mode = ser_active && bus_in[LANE_TXEN];
  assign rx_mode = ser_active && !bus_in[LANE_TXEN];

  assign utx_en  = tx_mode;
  assign utx_dat = tx_mode && bus_in[LANE_DAT];
  assign utx_se0 = tx_mode && bus_in[LANE_SE0];

  assign bus_out[LANE_TXEN] = 1'b0;
  assign bus_oe[LANE_TXEN]  = 1'b0;
  assign bus_out[LANE_DAT]  = rx_mode && dp_sync;
  assign bus_oe[LANE_DAT]   = rx_mode;
  assign bus_out[LANE_SE0]  = rx_mode && se0_sync;
  assign bus_oe[LANE_SE0]   = rx_mode;
  assign bus_out[LANE_IRQ]  = ser_active && irq_level;
  assign bus_oe[LANE_IRQ]   = ser_active;

  generate
    for (genvar i = 4; i < BUS_W; i++) begin : g_quiet
      assign bus_out[i] = 1'b0;
      assign bus_oe[i]  = 1'b0;
    end
  endgenerate

  // R4: upper lanes never driven
  p_hi_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe[BUS_W-1:4] == '0) && (bus_out[BUS_W-1:4] == '0));

  // R5: transmit direction releases data and SE0 lanes
  p_tx_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    utx_en |-> (!bus_oe[LANE_DAT] && !bus_oe[LANE_SE0]));

  // R6: receive direction drives both lanes and silences the line drivers
  p_rx_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_active && !utx_en) |-> (bus_oe[LANE_DAT] && bus_oe[LANE_SE0] && !utx_dat && !utx_se0));

endmodule

// File: rtl/ulpi_serial3_ctrl.sv
module ulpi_serial3_ctrl
  import u3s_pkg::*;
#(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned N_IRQ       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IFC_ADDR = 6'h07,
  parameter logic [ADDR_W-1:0] IEN_ADDR = 6'h0E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] ulpi_data_in,
  output logic [BUS_W-1:0] ulpi_data_out,
  output logic [BUS_W-1:0] ulpi_data_oe,
  output logic             ulpi_dir,
  output logic             ulpi_nxt,
  input  logic             ulpi_stp,
  input  logic             line_dp_rx,
  input  logic             line_se0_rx,
  output logic             usb_tx_en,
  output logic             usb_tx_dat,
  output logic             usb_tx_se0,
  input  logic [N_IRQ-1:0] irq_src,
  output logic             clkout_en
);

  logic              ser_active;
  logic              clk_keep;
  logic [N_IRQ-1:0]  irq_mask;
  logic              exit_evt;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [BUS_W-1:0]  wr_data;
  logic              irq_level;
  logic [1:0]        line_sync;

  assign exit_evt  = ser_active && ulpi_stp;
  assign irq_level = irq_any(16'(irq_src), 16'(irq_mask));
  assign clkout_en = clk_running(ser_active, clk_keep);
  assign ulpi_dir  = ser_active;

  u3s_regwr #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_regwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (ser_active),
    .bus_in   (ulpi_data_in),
    .stp      (ulpi_stp),
    .nxt      (ulpi_nxt),
    .wr_commit(wr_commit),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  u3s_ctrlregs #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .N_IRQ(N_IRQ),
    .IFC_ADDR(IFC_ADDR), .IEN_ADDR(IEN_ADDR)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_commit(wr_commit),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .exit_evt (exit_evt),
    .ser_en   (ser_active),
    .clk_keep (clk_keep),
    .irq_mask (irq_mask)
  );

  u3s_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({line_dp_rx, line_se0_rx}),
    .q    (line_sync)
  );

  u3s_busmux #(.BUS_W(BUS_W)) i_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_active(ser_active),
    .bus_in    (ulpi_data_in),
    .dp_sync   (line_sync[1]),
    .se0_sync  (line_sync[0]),
    .irq_level (irq_level),
    .bus_out   (ulpi_data_out),
    .bus_oe    (ulpi_data_oe),
    .utx_en    (usb_tx_en),
    .utx_dat   (usb_tx_dat),
    .utx_se0   (usb_tx_se0)
  );

  // R10: no command accept while the bus is repurposed
  p_no_nxt_serial_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_active |-> !ulpi_nxt);

  // R9: clock gated in serial mode without the keep bit
  p_clk_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir && !clk_keep) |-> !clkout_en);

  // R8: direction returns low after a stop in serial mode
  p_dir_low_after_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (!ulpi_dir && ulpi_data_oe == '0));

  // R7: interrupt lane reflects any unmasked active source
  p_irq_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir && |(irq_src & irq_mask)) |-> ulpi_data_out[LANE_IRQ]);

endmodule

// File: tb/test_ulpi_serial3_ctrl.sv
module test_ulpi_serial3_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] data_in;
  logic [7:0] data_out, data_oe;
  logic       dir, nxt, stp;
  logic       ldp, lse0;
  logic       utx_en, utx_dat, utx_se0;
  logic [3:0] src;
  logic       clk_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ulpi_serial3_ctrl i_ulpi_serial3_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ulpi_data_in(data_in), .ulpi_data_out(data_out), .ulpi_data_oe(data_oe),
    .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_stp(stp),
    .line_dp_rx(ldp), .line_se0_rx(lse0),
    .usb_tx_en(utx_en), .usb_tx_dat(utx_dat), .usb_tx_se0(utx_se0),
    .irq_src(src), .clkout_en(clk_en)
  );

  // stimulus {txen, lane1, lane2, line_dp, line_se0, src[3:0]}
  // expected {oe[3:0], out[3:0], tx_en, tx_dat, tx_se0}; mask = 4'b0101
  localparam int NV = 8;
  localparam logic [8:0]  VIN  [NV] = '{
    9'b0_0_0_1_0_0000, 9'b0_0_0_0_1_0001, 9'b1_1_0_1_1_0010, 9'b1_0_1_0_0_0100,
    9'b1_1_1_0_0_1000, 9'b0_1_1_1_1_1111, 9'b0_0_0_0_0_1010, 9'b1_0_0_1_0_0101};
  localparam logic [10:0] VEXP [NV] = '{
    11'b1110_0010_000, 11'b1110_1100_000, 11'b1000_0000_110, 11'b1000_1000_101,
    11'b1000_0000_111, 11'b1110_1110_000, 11'b1110_0000_000, 11'b1000_1000_100};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // register write; strobe checked along the way (R2)
  task automatic wr(input logic [5:0] addr, input logic [7:0] val);
    data_in = {2'b10, addr};
    cyc();
    check("R2 nxt after command", nxt, 1);
    data_in = val;
    cyc();
    check("R2 nxt drops", nxt, 0);
    data_in = 8'h00;
    stp = 1'b1;
    cyc();
    stp = 1'b0;
  endtask

  task automatic leave_serial();
    data_in = 8'h00;
    stp = 1'b1;
    cyc();
    stp = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; data_in = '0; stp = 1'b0; ldp = 1'b0; lse0 = 1'b0; src = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 dir", dir, 0);
    check("R1 nxt", nxt, 0);
    check("R1 oe", data_oe, 0);
    check("R1 clkout_en", clk_en, 1);
    check("R1 tx_en", utx_en, 0);

    // R3 unused address
    wr(6'h05, 8'h01);
    check("R3 unused address ignored", dir, 0);
    // R3 stop during strobe
    data_in = 8'h87;
    cyc();
    check("R2 nxt for abort cmd", nxt, 1);
    data_in = 8'h01; stp = 1'b1;
    cyc();
    stp = 1'b0; data_in = 8'h00;
    check("R3 aborted write nxt", nxt, 0);
    cyc();
    check("R3 aborted write dir", dir, 0);

    // R4/R9 enter serial without keep
    wr(6'h07, 8'h01);
    check("R4 dir high", dir, 1);
    check("R4 irq lane driven", data_oe[3], 1);
    check("R4 upper oe", data_oe[7:4], 0);
    check("R4 upper out", data_out[7:4], 0);
    check("R9 clock stopped", clk_en, 0);
    // R7 mask resets to 0
    src = 4'hF;
    cyc();
    check("R7 reset mask blocks irq", data_out[3], 0);
    src = 4'h0;
    // R10 no command decode in serial mode
    data_in = 8'h87;
    cyc();
    cyc();
    check("R10 nxt stays low", nxt, 0);
    check("R5 tx_en from lane0", utx_en, 1);
    // R6 two-edge receive delay
    data_in = 8'h00; ldp = 1'b0;
    repeat (3) cyc();
    ldp = 1'b1;
    cyc();
    check("R6 dp after one edge", data_out[1], 0);
    cyc();
    check("R6 dp after two edges", data_out[1], 1);
    // R8 exit
    leave_serial();
    check("R8 dir low", dir, 0);
    check("R8 all lanes released", data_oe, 0);
    check("R9 clock runs outside serial", clk_en, 1);

    // R7 mask, R9 keep bit, then vector table
    wr(6'h0E, 8'h05);
    check("R8 writes work after exit", dir, 0);
    wr(6'h07, 8'h03);
    check("R9 clock kept", clk_en, 1);
    for (int v = 0; v < NV; v++) begin
      data_in = {5'b0, VIN[v][6], VIN[v][7], VIN[v][8]};
      ldp = VIN[v][5]; lse0 = VIN[v][4]; src = VIN[v][3:0];
      repeat (3) cyc();
      check($sformatf("R5 R6 R7 vector %0d", v),
            {data_oe[3:0], data_out[3:0], utx_en, utx_dat, utx_se0}, VEXP[v]);
    end
    leave_serial();
    check("R8 second exit", dir, 0);
    wr(6'h07, 8'h01);
    check("R8 re-entry", dir, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule